// File: doc/BRIEF.md
# Burst-Four Double-Rate Separate-Port SRAM Model

This block is a synthesizable, small-depth behavioural model of a synchronous static memory that has a read data port and a write data port. Every access moves a fixed burst of four full-width words, one word per half-cycle. The block runs on one fast clock at twice the command rate. An input phase flag marks each fast edge as either a "K rise" (flag high) or a "K# rise" (flag low). Commands and the shared address are taken only on K-rise edges. Write data and byte enables arrive on both phases. Read data leaves on both phases, and an echoed phase flag travels alongside it.

A write is held in a late-write buffer until its fourth beat has arrived. The whole burst is then committed to the array in one step, with byte masking. Reads fetch each word as it is emitted, 2.5 command cycles after the read command. Because of this timing, a read always returns every write whose command came before it, even one whose data is still in the buffer, and never returns a write whose command came after it. The model serves as a stand-in for an external burst SRAM in system simulation and on prototyping fabric.

Top module: `qburst_sram`

## Requirements
- R1: A command address `addr` selects a four-word-aligned group: burst beat k (k = 0..3) of any read or write accesses word 4*addr + k, and each beat carries one full `DATA_W`-bit word.
- R2: `rdSel`, `wrSel` and `addr` take effect only on a fast edge where `kPhase` = 1. A command presented on a `kPhase` = 0 edge has no effect on memory or on the read port.
- R3: For a write accepted at fast edge T, beat k is sampled from `wrData`/`byteEn` at edge T+2+k. Beats 0 and 2 therefore land on K-rise edges, and beats 1 and 3 on K#-rise edges.
- R4: `byteEn` bit l governs bits [LANE_W*l+LANE_W-1 : LANE_W*l] of the beat sampled with it. A cleared bit leaves that lane of the stored word unchanged, and an all-zero mask across a burst changes nothing.
- R5: For a read accepted at fast edge T, beat k is registered onto `rdData` at edge T+5+k. The first beat leaves on a K#-rise edge, and `echoPhase` equals the `kPhase` value of the previous fast edge (0 during beats 1 and 3, 1 during beats 2 and 4).
- R6: A read command on the K-rise edge right after an accepted read is ignored. The same holds for a write command on the K-rise edge right after an accepted write. Commands two K cycles apart are accepted, and a read and a write may alternate on successive K-rise edges.
- R7: When `rdSel` and `wrSel` are both high on a K-rise edge, only the read is performed and the write is dropped.
- R8: `rdValid` is high for exactly the four fast cycles that carry each read's beats, and `rdData` is zero whenever `rdValid` is low.
- R9: A read sees every write whose command came earlier, including one only one K cycle earlier whose data is still buffered. It does not see a write whose command comes later.
- R10: While `rstN` is low, `rdValid`, `rdData` and `echoPhase` are zero. A read or write in flight when reset is asserted is abandoned, and an abandoned write leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two edges per command cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| kPhase | input | 1 | High on K-rise edges, low on K#-rise edges |
| addr | input | GRP_W | Burst group address, shared by reads and writes |
| rdSel | input | 1 | Read command request |
| wrSel | input | 1 | Write command request |
| wrData | input | DATA_W | Write beat data |
| byteEn | input | LANES | Per-lane write enables for the current beat |
| rdData | output | DATA_W | Read beat data, zero when idle |
| rdValid | output | 1 | High while a read beat is on `rdData` |
| echoPhase | output | 1 | Phase flag of the edge that launched the current output |

## Verification
The bench targets the timing edges of the late-write buffer. It reads a group one K cycle after writing it, and writes a group one K cycle after reading it. A design that commits too late returns stale data in the first case, and one that commits beat by beat as data arrives leaks future data into the second. Rejection cases are checked by their effect on later reads: odd-phase commands, back-to-back same-kind commands and a simultaneous read and write. A design that accepts any of them would corrupt a group or put a read's beats on the bus at the wrong time. Partial and all-zero byte masks, and a reset that lands in the middle of a write and a pending read, catch lane mis-mapping and writes that commit after being abandoned.

// File: rtl/qburst_pkg.sv
package qburst_pkg;

  // Fixed burst shape and pipeline offsets, in fast-clock edges.
  localparam int BEATS   = 4;
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int WR_LEAD = 2;                  // command edge to first write beat
  localparam int RD_LAT  = 5;                  // command edge to first read beat register
  localparam int WR_DONE = WR_LEAD + BEATS;    // command edge to whole-burst commit

  // Strobes passed from control to datapath on every fast edge.
  typedef struct packed {
    logic              rdTake;      // read command accepted now
    logic              wrTake;      // write command accepted now
    logic              wrAddrMove;  // move held write address to commit slot
    logic              wrBeatCap;   // capture one write beat into the buffer
    logic [BEAT_W-1:0] wrBeatIdx;
    logic              wrCommit;    // write whole buffer into the array
    logic              rdAddrMove;  // move held read address to emit slot
    logic              rdEmit;      // register one read beat onto the port
    logic [BEAT_W-1:0] rdBeatIdx;
  } qbStrobeT;

endpackage

// File: rtl/qburst_ctrl.sv
module qburst_ctrl
  import qburst_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     kPhase,
  input  logic     rdSel,
  input  logic     wrSel,
  output qbStrobeT strb,
  output logic     echoPhase
);

  localparam int RD_PIPE = RD_LAT + BEATS - 1;
  localparam int WR_PIPE = WR_DONE;

  // Bit i set: a command of that kind was accepted i+1 edges ago.
  logic [RD_PIPE-1:0] rdPipe;
  logic [WR_PIPE-1:0] wrPipe;
  logic               rdTake;
  logic               wrTake;

  // A command holds its kind for two K cycles; the read owns a shared bus edge.
  assign rdTake = kPhase & rdSel & ~rdPipe[1];
  assign wrTake = kPhase & wrSel & ~rdSel & ~wrPipe[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe    <= '0;
      wrPipe    <= '0;
      echoPhase <= 1'b0;
    end else begin
      rdPipe    <= {rdPipe[RD_PIPE-2:0], rdTake};
      wrPipe    <= {wrPipe[WR_PIPE-2:0], wrTake};
      echoPhase <= kPhase;
    end
  end

  always_comb begin
    strb            = '0;
    strb.rdTake     = rdTake;
    strb.wrTake     = wrTake;
    strb.wrAddrMove = wrPipe[WR_LEAD-1];
    strb.wrCommit   = wrPipe[WR_PIPE-1];
    strb.rdAddrMove = rdPipe[RD_LAT-2];
    for (int k = 0; k < BEATS; k++) begin
      if (wrPipe[WR_LEAD-1+k]) begin
        strb.wrBeatCap = 1'b1;
        strb.wrBeatIdx = BEAT_W'(k);
      end
      if (rdPipe[RD_LAT-1+k]) begin
        strb.rdEmit    = 1'b1;
        strb.rdBeatIdx = BEAT_W'(k);
      end
    end
  end

  // A commit must trace back to a write request taken WR_DONE edges earlier.
  AST_COMMIT_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> $past(wrSel && kPhase && !rdSel, 6)); // R3

endmodule

// File: rtl/qburst_dpath.sv
module qburst_dpath
  import qburst_pkg::*;
#(
  parameter  int LANE_W = 9,
  parameter  int LANES  = 4,
  parameter  int GROUPS = 64,
  localparam int DATA_W = LANE_W * LANES,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int WORDS  = GROUPS * BEATS,
  localparam int WADR_W = GRP_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  qbStrobeT          strb,
  input  logic [GRP_W-1:0]  addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [GRP_W-1:0]  wrAddrHold;
  logic [GRP_W-1:0]  wrAddrCommit;
  logic [GRP_W-1:0]  rdAddrHold;
  logic [GRP_W-1:0]  rdAddrEmit;
  logic [DATA_W-1:0] wrBuf   [BEATS];
  logic [LANES-1:0]  wrEnBuf [BEATS];
  logic [LANE_W-1:0] laneRd  [LANES];
  logic [DATA_W-1:0] rdWord;
  logic [WADR_W-1:0] rdIdx;

  // Address staging: a second command of a kind may arrive before the first is done.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrHold   <= '0;
      wrAddrCommit <= '0;
      rdAddrHold   <= '0;
      rdAddrEmit   <= '0;
    end else begin
      if (strb.wrTake)     wrAddrHold   <= addr;
      if (strb.wrAddrMove) wrAddrCommit <= wrAddrHold;
      if (strb.rdTake)     rdAddrHold   <= addr;
      if (strb.rdAddrMove) rdAddrEmit   <= rdAddrHold;
    end
  end

  // Late-write buffer: four beats with their lane enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < BEATS; k++) begin
        wrBuf[k]   <= '0;
        wrEnBuf[k] <= '0;
      end
    end else if (strb.wrBeatCap) begin
      wrBuf[strb.wrBeatIdx]   <= wrData;
      wrEnBuf[strb.wrBeatIdx] <= byteEn;
    end
  end

  assign rdIdx = {rdAddrEmit, strb.rdBeatIdx};

  // One storage column per byte lane; a lane is written only where enabled.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [WORDS];

    always_ff @(posedge clk) begin
      if (strb.wrCommit) begin
        for (int k = 0; k < BEATS; k++) begin
          if (wrEnBuf[k][l]) begin
            laneMem[{wrAddrCommit, BEAT_W'(k)}] <= wrBuf[k][l*LANE_W +: LANE_W];
          end
        end
      end
    end

    assign laneRd[l] = laneMem[rdIdx];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rdWord[l*LANE_W +: LANE_W] = laneRd[l];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEmit;
      rdData  <= strb.rdEmit ? rdWord : '0;
    end
  end

  // Beat capture never overlaps a buffer slot being committed for the same burst.
  AST_BEAT_BEFORE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> $past(strb.wrBeatCap && strb.wrBeatIdx == BEAT_W'(BEATS-1), 1)); // R3

endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
  import qburst_pkg::*;
#(
  parameter  int LANE_W = 9,
  parameter  int LANES  = 4,
  parameter  int GROUPS = 64,
  localparam int DATA_W = LANE_W * LANES,
  localparam int GRP_W  = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kPhase,
  input  logic [GRP_W-1:0]  addr,
  input  logic              rdSel,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              echoPhase
);

  qbStrobeT strb;

  qburst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .kPhase    (kPhase),
    .rdSel     (rdSel),
    .wrSel     (wrSel),
    .strb      (strb),
    .echoPhase (echoPhase)
  );

  qburst_dpath #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .GROUPS (GROUPS)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .wrData  (wrData),
    .byteEn  (byteEn),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(rdSel && kPhase, 6)); // R5

  AST_FIRST_BEAT_KSHARP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> !echoPhase); // R5

  AST_VALID_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid ##1 rdValid ##1 rdValid); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0); // R8

endmodule

// File: tb/qburst_sram_tb.sv
module qburst_sram_tb;

  localparam int CLK_P = 4;
  localparam int LW    = 9;
  localparam int LN    = 4;
  localparam int DW    = LW * LN;
  localparam int GR    = 64;
  localparam int GW    = 6;
  localparam int NE    = 80;

  logic          clk = 1'b0;
  logic          rstN;
  logic          kPhase;
  logic [GW-1:0] addr;
  logic          rdSel;
  logic          wrSel;
  logic [DW-1:0] wrData;
  logic [LN-1:0] byteEn;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic          echoPhase;

  always #(CLK_P/2) clk = ~clk;

  qburst_sram #(.LANE_W(LW), .LANES(LN), .GROUPS(GR)) u_dut (
    .clk(clk), .rstN(rstN), .kPhase(kPhase), .addr(addr), .rdSel(rdSel),
    .wrSel(wrSel), .wrData(wrData), .byteEn(byteEn), .rdData(rdData),
    .rdValid(rdValid), .echoPhase(echoPhase)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // Per-edge schedule and expectations; edge e has kPhase = (e even).
  bit            sRst [NE];
  bit            sRd  [NE];
  bit            sWr  [NE];
  logic [GW-1:0] sAddr[NE];
  logic [DW-1:0] sData[NE];
  logic [LN-1:0] sEn  [NE];
  bit            eV   [NE];
  bit            eC   [NE];
  logic [DW-1:0] eD   [NE];
  int            eTag [NE];

  logic [DW-1:0] refMem[GR*4];
  bit            known [GR*4];

  typedef struct packed {
    logic [7:0]    at;
    logic          rd;
    logic          wr;
    logic [GW-1:0] grp;
    logic [7:0]    seed;
    logic [15:0]   en;    // beat k uses bits [4k+3:4k], bit l = lane l
    logic [7:0]    tag;
  } vecT;

  localparam int NV = 23;
  localparam vecT VEC [NV] = '{
    '{8'd0,  1'b0, 1'b1, 6'd1, 8'h11, 16'hFFFF, 8'd1},  // R1 fill g1
    '{8'd4,  1'b0, 1'b1, 6'd2, 8'h22, 16'hFFFF, 8'd1},  // R1 fill g2
    '{8'd8,  1'b1, 1'b0, 6'd1, 8'h00, 16'h0000, 8'd1},  // R1 read g1
    '{8'd10, 1'b0, 1'b1, 6'd3, 8'h33, 16'hFFFF, 8'd3},  // R3 write after read
    '{8'd12, 1'b1, 1'b0, 6'd2, 8'h00, 16'h0000, 8'd1},  // R1 back-to-back read
    '{8'd14, 1'b0, 1'b1, 6'd1, 8'h44, 16'hA5C3, 8'd4},  // R4 partial mask
    '{8'd16, 1'b1, 1'b0, 6'd1, 8'h00, 16'h0000, 8'd9},  // R9 read of buffered write
    '{8'd20, 1'b1, 1'b0, 6'd2, 8'h00, 16'h0000, 8'd9},  // R9 read before later write
    '{8'd22, 1'b0, 1'b1, 6'd2, 8'h66, 16'hFFFF, 8'd9},
    '{8'd24, 1'b1, 1'b0, 6'd2, 8'h00, 16'h0000, 8'd9},
    '{8'd26, 1'b1, 1'b0, 6'd3, 8'h00, 16'h0000, 8'd6},  // R6 read too soon
    '{8'd28, 1'b1, 1'b1, 6'd3, 8'h77, 16'hFFFF, 8'd7},  // R7 both selects
    '{8'd30, 1'b0, 1'b1, 6'd5, 8'h88, 16'hFFFF, 8'd3},
    '{8'd32, 1'b0, 1'b1, 6'd3, 8'h99, 16'hFFFF, 8'd6},  // R6 write too soon
    '{8'd34, 1'b1, 1'b0, 6'd3, 8'h00, 16'h0000, 8'd7},  // R7 dropped write absent
    '{8'd35, 1'b1, 1'b0, 6'd1, 8'h00, 16'h0000, 8'd2},  // R2 odd-phase read
    '{8'd37, 1'b0, 1'b1, 6'd1, 8'hBB, 16'hFFFF, 8'd2},  // R2 odd-phase write
    '{8'd38, 1'b1, 1'b0, 6'd5, 8'h00, 16'h0000, 8'd3},
    '{8'd42, 1'b1, 1'b0, 6'd1, 8'h00, 16'h0000, 8'd2},  // R2 g1 untouched
    '{8'd44, 1'b0, 1'b1, 6'd2, 8'hAA, 16'h0000, 8'd4},  // R4 empty mask
    '{8'd48, 1'b1, 1'b0, 6'd2, 8'h00, 16'h0000, 8'd4},
    '{8'd50, 1'b0, 1'b1, 6'd5, 8'hCC, 16'h0F0F, 8'd4},
    '{8'd52, 1'b1, 1'b0, 6'd5, 8'h00, 16'h0000, 8'd9}   // R9 merged buffered write
  };

  function automatic logic [DW-1:0] beatVal(logic [7:0] seed, int k);
    return {seed, 6'(k), seed ^ 8'h5A, 6'(k + 3), 8'hC3};
  endfunction

  function automatic logic [DW-1:0] mergeLanes(logic [DW-1:0] old, logic [DW-1:0] nw,
                                               logic [LN-1:0] en);
    logic [DW-1:0] w = old;
    for (int l = 0; l < LN; l++) if (en[l]) w[l*LW +: LW] = nw[l*LW +: LW];
    return w;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearSched();
    for (int e = 0; e < NE; e++) begin
      sRst[e] = 0; sRd[e] = 0; sWr[e] = 0; sAddr[e] = '0;
      sData[e] = '1; sEn[e] = '1;            // bus noise that must be ignored
      eV[e] = 0; eC[e] = 0; eD[e] = '0; eTag[e] = 8;
    end
  endtask

  task automatic observe(input int e);
    if (sRst[e]) begin
      chk("R10 valid in reset", DW'(rdValid), '0);
      chk("R10 data in reset", rdData, '0);
      chk("R10 echo in reset", DW'(echoPhase), '0);
    end else begin
      chk($sformatf("R8 R5 valid at edge %0d", e), DW'(rdValid), DW'(eV[e]));
      if (eV[e] && eC[e]) chk($sformatf("R%0d data at edge %0d", eTag[e], e), rdData, eD[e]);
      if (!eV[e]) chk($sformatf("R8 idle data at edge %0d", e), rdData, '0);
      chk($sformatf("R5 echo at edge %0d", e), DW'(echoPhase), DW'(e % 2 == 0));
    end
  endtask

  task automatic runSched(input int n);
    for (int e = 0; e < n; e++) begin
      @(negedge clk);
      if (e > 0) observe(e - 1);
      rstN   = !sRst[e];
      kPhase = (e % 2 == 0);
      rdSel  = sRd[e];
      wrSel  = sWr[e];
      addr   = sAddr[e];
      wrData = sData[e];
      byteEn = sEn[e];
    end
    @(negedge clk);
    observe(n - 1);
    rstN = 1'b1; kPhase = 1'b1; rdSel = 1'b0; wrSel = 1'b0;
  endtask

  // Reference model built from the acceptance, timing and merge rules.
  task automatic buildTable();
    int lastRd = -100;
    int lastWr = -100;
    for (int i = 0; i < NV; i++) begin
      vecT v = VEC[i];
      int  e = int'(v.at);
      bit  kp = (e % 2 == 0);
      sRd[e] = v.rd; sWr[e] = v.wr; sAddr[e] = v.grp;
      if (kp && v.rd && (e - lastRd) != 2) begin
        lastRd = e;
        for (int k = 0; k < 4; k++) begin
          int idx = int'(v.grp) * 4 + k;
          eV[e+5+k] = 1; eC[e+5+k] = known[idx]; eD[e+5+k] = refMem[idx];
          eTag[e+5+k] = int'(v.tag);
        end
      end else if (kp && v.wr && !v.rd && (e - lastWr) != 2) begin
        lastWr = e;
        for (int k = 0; k < 4; k++) begin
          int idx = int'(v.grp) * 4 + k;
          sData[e+2+k] = beatVal(v.seed, k);
          sEn[e+2+k]   = v.en[4*k +: 4];
          refMem[idx]  = mergeLanes(refMem[idx], beatVal(v.seed, k), v.en[4*k +: 4]);
          known[idx]   = 1;
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < GR*4; i++) begin refMem[i] = '0; known[i] = 0; end
    rstN = 1'b0; kPhase = 1'b0; rdSel = 1'b0; wrSel = 1'b0;
    addr = '0; wrData = '0; byteEn = '0;
    repeat (4) @(negedge clk);
    chk("R10 reset valid", DW'(rdValid), '0);
    chk("R10 reset data", rdData, '0);
    chk("R10 reset echo", DW'(echoPhase), '0);
    rstN = 1'b1;

    // Table-driven main sequence.
    clearSched();
    buildTable();
    runSched(64);

    // Directed: reset lands inside a write burst and a pending read (R10).
    clearSched();
    sWr[0] = 1; sAddr[0] = 6'd1;
    for (int k = 0; k < 4; k++) begin sData[2+k] = beatVal(8'hDD, k); sEn[2+k] = 4'hF; end
    sRd[2] = 1; sAddr[2] = 6'd1;
    sRst[4] = 1; sRst[5] = 1;
    sRd[8] = 1; sAddr[8] = 6'd1;
    for (int k = 0; k < 4; k++) begin
      eV[13+k] = 1; eC[13+k] = known[4+k]; eD[13+k] = refMem[4+k]; eTag[13+k] = 10;
    end
    runSched(20);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule